// File: doc/BRIEF.md
# SCSI Controller CPU Register Interface

This block is the processor-facing register file and address decoder of a SCSI bus controller. A host processor reaches eight locations through a 3-bit address qualified by an active-low chip select and active-low read and write strobes. Every location has one meaning when read and a different one when written. Some locations hold configuration bytes for the rest of the controller. Others return live bus or status values supplied by neighbouring blocks. The upper write locations are command strobes and store nothing.

A DMA controller can reach the data path without chip select by asserting DMA acknowledge. A read then returns the input data byte, and a write loads the output data byte, whatever the address lines carry. The processor data bus is split into an input byte, an output byte and an output-enable. The pad ring merges them into a tristate bus. All strobes are sampled on the block clock. Each access takes effect once, at its first sampled cycle. Bus phase sequencing, pad drivers and parity lie outside this block.

Top module: `scsi_regif`

## Requirements
- R1: Asserting `rst_n` low clears out_data, icmd, mode, tcmd, sel_en, the input data byte and all four pulse outputs to zero.
- R2: A write access is `wr_n` low together with `cs_n` low. On the first sampled cycle of the access, d_in is stored into the register at `addr`: 0 to out_data, 1 to icmd, 2 to mode, 3 to tcmd, 4 to sel_en. The new value appears on the register's port one clock later.
- R3: A read access is `rd_n` low together with `cs_n` low, and d_out shows a value selected by `addr`: 0 the live bus byte, 1 icmd, 2 mode, 3 tcmd, 4 bus_stat, 5 bus_and_stat, 6 the input data byte, 7 zero.
- R4: d_oe is high only during a read access (with chip select or DMA acknowledge), and d_out is zero whenever d_oe is low.
- R5: A write access to address 5, 6 or 7 raises start_send, start_trecv or start_irecv respectively, for exactly one cycle per access, in the cycle after the first sampled access cycle. No register changes.
- R6: With `dack_n` low, a write stores d_in into out_data and a read returns the input data byte, regardless of `addr` and `cs_n`.
- R7: A read access to address 7 raises clr_pi for exactly one cycle per access, in the cycle after the first sampled access cycle.
- R8: Strobes with both `cs_n` and `dack_n` high change no register, raise no pulse and leave d_oe low.
- R9: When in_latch is high at a clock edge, the input data byte takes the value of scsi_live.
- R10: When `cs_n` and `dack_n` are both low, the DMA meaning wins: a write goes to out_data, not to the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| addr | input | 3 | Register address |
| d_in | input | 8 | Processor write data |
| d_out | output | 8 | Processor read data |
| d_oe | output | 1 | Read data output enable for the pad |
| scsi_live | input | 8 | Live SCSI data bus byte |
| bus_stat | input | 8 | Current bus signal status |
| bus_and_stat | input | 8 | Combined bus and controller status |
| in_latch | input | 1 | Capture scsi_live into the input data byte |
| out_data | output | 8 | Output data register |
| icmd | output | 8 | Initiator command register |
| mode | output | 8 | Mode register |
| tcmd | output | 8 | Target command register |
| sel_en | output | 8 | Select enable register |
| start_send | output | 1 | Start DMA send pulse |
| start_trecv | output | 1 | Start DMA target receive pulse |
| start_irecv | output | 1 | Start DMA initiator receive pulse |
| clr_pi | output | 1 | Reset parity/interrupt pulse |

## Verification
A wrong decode or a missed store shows on the register output ports one clock after the access begins, so every write is followed by a comparison of all five stored bytes. A bad read mux or output-enable appears at once on d_out and d_oe within the same cycle. A broken edge detector shows as a pulse that stays high for a second cycle of a held strobe, and each pulse is checked both in its expected cycle and in the cycle that follows.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SLOT_DATA   = 3'd0,
    SLOT_ICMD   = 3'd1,
    SLOT_MODE   = 3'd2,
    SLOT_TCMD   = 3'd3,
    SLOT_STAT   = 3'd4,
    SLOT_BSTAT  = 3'd5,
    SLOT_INDATA = 3'd6,
    SLOT_CLR    = 3'd7
  } reg_slot_e;

  localparam int PULSE_BASE = 5;
  localparam int PULSE_N    = 3;

  // DMA acknowledge overrides the address for writes.
  function automatic reg_slot_e write_slot(input logic dma, input logic [ADDR_W-1:0] a);
    return dma ? SLOT_DATA : reg_slot_e'(a);
  endfunction

  // DMA acknowledge overrides the address for reads.
  function automatic reg_slot_e read_slot(input logic dma, input logic [ADDR_W-1:0] a);
    return dma ? SLOT_INDATA : reg_slot_e'(a);
  endfunction

  // An access needs a strobe plus chip select or DMA acknowledge.
  function automatic logic access_on(input logic strobe_n, input logic cs_n, input logic dack_n);
    return !strobe_n && (!cs_n || !dack_n);
  endfunction

endpackage

// File: rtl/scsi_regif_access.sv
module scsi_regif_access
  import scsi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              dack_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_act,
  output logic              rd_evt,
  output logic              wr_evt,
  output reg_slot_e         slot_r,
  output reg_slot_e         slot_w
);

  logic wr_act;
  logic rd_prev, wr_prev;

  assign rd_act = access_on(rd_n, cs_n, dack_n);
  assign wr_act = access_on(wr_n, cs_n, dack_n);
  assign slot_r = read_slot(!dack_n, addr);
  assign slot_w = write_slot(!dack_n, addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
    end
  end

  // One event per access, at its first sampled cycle.
  assign rd_evt = rd_act && !rd_prev;
  assign wr_evt = wr_act && !wr_prev;

  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  a_r7_single_read_event: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt);

endmodule

// File: rtl/scsi_regif_store.sv
module scsi_regif_store
  import scsi_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  reg_slot_e         slot_w,
  input  reg_slot_e         slot_r,
  input  logic [DATA_W-1:0] d_in,
  input  logic              in_latch,
  input  logic [DATA_W-1:0] scsi_live,
  output logic [DATA_W-1:0] out_data_q,
  output logic [DATA_W-1:0] icmd_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] tcmd_q,
  output logic [DATA_W-1:0] sel_en_q,
  output logic [DATA_W-1:0] in_data_q,
  output logic [PULSE_N-1:0] start_q,
  output logic              clr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data_q <= '0;
      icmd_q     <= '0;
      mode_q     <= '0;
      tcmd_q     <= '0;
      sel_en_q   <= '0;
    end else if (wr_evt) begin
      case (slot_w)
        SLOT_DATA: out_data_q <= d_in;
        SLOT_ICMD: icmd_q     <= d_in;
        SLOT_MODE: mode_q     <= d_in;
        SLOT_TCMD: tcmd_q     <= d_in;
        SLOT_STAT: sel_en_q   <= d_in;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_data_q <= '0;
    else if (in_latch) in_data_q <= scsi_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else clr_q <= rd_evt && (slot_r == SLOT_CLR);
  end

  for (genvar g = 0; g < PULSE_N; g++) begin : g_pulse
    localparam logic [ADDR_W-1:0] SL = ADDR_W'(PULSE_BASE + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q[g] <= 1'b0;
      else start_q[g] <= wr_evt && (slot_w == reg_slot_e'(SL));
    end
    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      start_q[g] |=> !start_q[g]);
  end

  a_r2_mode_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && slot_w == SLOT_MODE) |=> (mode_q == $past(d_in)));
  a_r5_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && slot_w == SLOT_MODE) |=> $stable(mode_q));
  a_r6_out_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && slot_w == SLOT_DATA) |=> (out_data_q == $past(d_in)));
  a_r9_latch: assert property (@(posedge clk) disable iff (!rst_n)
    in_latch |=> (in_data_q == $past(scsi_live)));
  a_r7_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);

endmodule

// File: rtl/scsi_regif_rdmux.sv
module scsi_regif_rdmux
  import scsi_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rd_act,
  input  reg_slot_e         slot_r,
  input  logic [DATA_W-1:0] scsi_live,
  input  logic [DATA_W-1:0] icmd_q,
  input  logic [DATA_W-1:0] mode_q,
  input  logic [DATA_W-1:0] tcmd_q,
  input  logic [DATA_W-1:0] bus_stat,
  input  logic [DATA_W-1:0] bus_and_stat,
  input  logic [DATA_W-1:0] in_data_q,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe
);

  logic [DATA_W-1:0] sel_val;

  always_comb begin
    case (slot_r)
      SLOT_DATA:   sel_val = scsi_live;
      SLOT_ICMD:   sel_val = icmd_q;
      SLOT_MODE:   sel_val = mode_q;
      SLOT_TCMD:   sel_val = tcmd_q;
      SLOT_STAT:   sel_val = bus_stat;
      SLOT_BSTAT:  sel_val = bus_and_stat;
      SLOT_INDATA: sel_val = in_data_q;
      default:     sel_val = '0;
    endcase
  end

  assign d_oe  = rd_act;
  assign d_out = rd_act ? sel_val : '0;

  always_comb begin
    a_r4_quiet_when_off: assert (d_oe || d_out == '0);
  end

endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              dack_n,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  input  logic [DATA_W-1:0] scsi_live,
  input  logic [DATA_W-1:0] bus_stat,
  input  logic [DATA_W-1:0] bus_and_stat,
  input  logic              in_latch,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] icmd,
  output logic [DATA_W-1:0] mode,
  output logic [DATA_W-1:0] tcmd,
  output logic [DATA_W-1:0] sel_en,
  output logic              start_send,
  output logic              start_trecv,
  output logic              start_irecv,
  output logic              clr_pi
);

  logic              rd_act, rd_evt, wr_evt;
  reg_slot_e         slot_r, slot_w;
  logic [DATA_W-1:0] in_data_q;
  logic [PULSE_N-1:0] start_q;

  scsi_regif_access u_access (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .dack_n (dack_n),
    .addr   (addr),
    .rd_act (rd_act),
    .rd_evt (rd_evt),
    .wr_evt (wr_evt),
    .slot_r (slot_r),
    .slot_w (slot_w)
  );

  scsi_regif_store #(.DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_evt     (wr_evt),
    .rd_evt     (rd_evt),
    .slot_w     (slot_w),
    .slot_r     (slot_r),
    .d_in       (d_in),
    .in_latch   (in_latch),
    .scsi_live  (scsi_live),
    .out_data_q (out_data),
    .icmd_q     (icmd),
    .mode_q     (mode),
    .tcmd_q     (tcmd),
    .sel_en_q   (sel_en),
    .in_data_q  (in_data_q),
    .start_q    (start_q),
    .clr_q      (clr_pi)
  );

  scsi_regif_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .rd_act       (rd_act),
    .slot_r       (slot_r),
    .scsi_live    (scsi_live),
    .icmd_q       (icmd),
    .mode_q       (mode),
    .tcmd_q       (tcmd),
    .bus_stat     (bus_stat),
    .bus_and_stat (bus_and_stat),
    .in_data_q    (in_data_q),
    .d_out        (d_out),
    .d_oe         (d_oe)
  );

  assign start_send  = start_q[0];
  assign start_trecv = start_q[1];
  assign start_irecv = start_q[2];

  a_r4_no_drive_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || (cs_n && dack_n)) |-> !d_oe);
  a_r8_no_pulse_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && dack_n) |=> !(start_send || start_trecv || start_irecv || clr_pi));
  a_r10_dma_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && !wr_n && !cs_n && addr == 3'd2) |=> $stable(mode));

endmodule

// File: tb/scsi_regif_bench.sv
module scsi_regif_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, rd_n, wr_n, dack_n, in_latch;
  logic [2:0] addr;
  logic [7:0] d_in, scsi_live, bus_stat, bus_and_stat;
  logic [7:0] d_out, out_data, icmd, mode, tcmd, sel_en;
  logic d_oe, start_send, start_trecv, start_irecv, clr_pi;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_out, m_icmd, m_mode, m_tcmd, m_sel, m_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regif u_scsi_regif (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .dack_n(dack_n), .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .scsi_live(scsi_live), .bus_stat(bus_stat), .bus_and_stat(bus_and_stat),
    .in_latch(in_latch), .out_data(out_data), .icmd(icmd), .mode(mode),
    .tcmd(tcmd), .sel_en(sel_en), .start_send(start_send),
    .start_trecv(start_trecv), .start_irecv(start_irecv), .clr_pi(clr_pi)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a, input bit dma);
    if (dma) return m_in;
    case (a)
      3'd0: return scsi_live;
      3'd1: return m_icmd;
      3'd2: return m_mode;
      3'd3: return m_tcmd;
      3'd4: return bus_stat;
      3'd5: return bus_and_stat;
      3'd6: return m_in;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_store(input string req);
    chk(out_data == m_out, req, out_data, m_out);
    chk(icmd == m_icmd, req, icmd, m_icmd);
    chk(mode == m_mode, req, mode, m_mode);
    chk(tcmd == m_tcmd, req, tcmd, m_tcmd);
    chk(sel_en == m_sel, req, sel_en, m_sel);
  endtask

  task automatic check_pulses(input bit es, input bit et, input bit ei, input bit ec, input string req);
    chk(start_send == es, req, {7'd0, start_send}, {7'd0, es});
    chk(start_trecv == et, req, {7'd0, start_trecv}, {7'd0, et});
    chk(start_irecv == ei, req, {7'd0, start_irecv}, {7'd0, ei});
    chk(clr_pi == ec, req, {7'd0, clr_pi}, {7'd0, ec});
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dack_n = 1'b1; in_latch = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_bus();
    m_out = 0; m_icmd = 0; m_mode = 0; m_tcmd = 0; m_sel = 0; m_in = 0;
    repeat (2) @(negedge clk);
    check_store("R1");
    check_pulses(0, 0, 0, 0, "R1");
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] v, input bit use_cs, input bit use_dack, input string req);
    bit acc;
    logic [2:0] eff;
    @(negedge clk);
    addr = a; d_in = v; cs_n = !use_cs; dack_n = !use_dack; wr_n = 1'b0;
    acc = use_cs || use_dack;
    eff = use_dack ? 3'd0 : a;
    @(posedge clk); @(negedge clk);
    if (acc) begin
      case (eff)
        3'd0: m_out = v;
        3'd1: m_icmd = v;
        3'd2: m_mode = v;
        3'd3: m_tcmd = v;
        3'd4: m_sel = v;
        default: ;
      endcase
    end
    check_pulses(acc && eff == 3'd5, acc && eff == 3'd6, acc && eff == 3'd7, 1'b0, req);
    check_store(req);
    @(posedge clk); @(negedge clk);
    check_pulses(0, 0, 0, 0, "R5");
    check_store(req);
    idle_bus();
  endtask

  task automatic do_read(input logic [2:0] a, input bit use_cs, input bit use_dack, input string req);
    bit acc;
    logic [7:0] e;
    @(negedge clk);
    addr = a; cs_n = !use_cs; dack_n = !use_dack; rd_n = 1'b0;
    acc = use_cs || use_dack;
    #1;
    e = acc ? exp_read(a, use_dack) : 8'h00;
    chk(d_oe == acc, "R4", {7'd0, d_oe}, {7'd0, acc});
    chk(d_out == e, req, d_out, e);
    @(posedge clk); @(negedge clk);
    check_pulses(0, 0, 0, acc && !use_dack && a == 3'd7, "R7");
    @(posedge clk); @(negedge clk);
    check_pulses(0, 0, 0, 0, "R7");
    idle_bus();
    #1;
    chk(d_oe == 1'b0, "R4", {7'd0, d_oe}, 8'h00);
  endtask

  task automatic do_latch(input logic [7:0] v);
    @(negedge clk);
    in_latch = 1'b1; scsi_live = v;
    @(posedge clk); @(negedge clk);
    in_latch = 1'b0;
    m_in = v;
    scsi_live = 8'h5A;
    do_read(3'd6, 1, 0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] r;
    seed = 32'h5C51;
    r = $urandom(seed);
    rst_n = 1'b0; addr = 0; d_in = 0;
    scsi_live = 8'h3C; bus_stat = 8'h81; bus_and_stat = 8'h42;
    idle_bus();
    do_reset();
    do_read(3'd6, 1, 0, "R1");

    // Directed: stores at addresses 0..4
    do_write(3'd0, 8'hA5, 1, 0, "R2");
    do_write(3'd1, 8'h11, 1, 0, "R2");
    do_write(3'd2, 8'h22, 1, 0, "R2");
    do_write(3'd3, 8'h33, 1, 0, "R2");
    do_write(3'd4, 8'h44, 1, 0, "R2");
    // Command strobes
    do_write(3'd5, 8'hFF, 1, 0, "R5");
    do_write(3'd6, 8'hFF, 1, 0, "R5");
    do_write(3'd7, 8'hFF, 1, 0, "R5");
    // Read map
    for (int a = 0; a < 8; a++) do_read(3'(a), 1, 0, "R3");
    // DMA path
    do_latch(8'hC3);
    do_write(3'd3, 8'h9E, 0, 1, "R6");
    do_read(3'd1, 0, 1, "R6");
    do_read(3'd7, 0, 1, "R6");
    // Both selects low
    do_write(3'd2, 8'h77, 1, 1, "R10");
    // Strobes without select
    do_write(3'd1, 8'hEE, 0, 0, "R8");
    do_write(3'd5, 8'hEE, 0, 0, "R8");
    do_read(3'd7, 0, 0, "R8");

    // Constrained random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      scsi_live = 8'($urandom); bus_stat = 8'($urandom); bus_and_stat = 8'($urandom);
      case (op)
        0, 1, 2: do_write(3'($urandom_range(0, 7)), 8'($urandom), 1, 0, "R2");
        3, 4:    do_read(3'($urandom_range(0, 7)), 1, 0, "R3");
        5:       do_write(3'($urandom_range(0, 7)), 8'($urandom), 0, 1, "R6");
        6:       do_read(3'($urandom_range(0, 7)), 0, 1, "R6");
        7:       do_write(3'($urandom_range(0, 7)), 8'($urandom), 0, 0, "R8");
        8:       do_latch(8'($urandom));
        default: do_write(3'($urandom_range(0, 7)), 8'($urandom), 1, 1, "R10");
      endcase
    end

    // Reset again after non-zero contents
    do_reset();
    do_read(3'd6, 1, 0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule